// File: doc/BRIEF.md
# Timer Compare and PWM Channel

This block is an up-counting timer with a single compare channel. A free-running counter steps once per `tick` while it is enabled. After it reaches the programmed reload value it wraps back to zero, and that wrap is the update event. The channel compares the count with a programmed compare value and builds a reference waveform in one of eight modes. The modes are: hold, set on match, clear on match, toggle on match, force low, force high, and two complementary PWM shapes. A polarity stage then maps "active" onto a pin level, and an output-enable stage decides whether the channel drives the pin at all.

Software reaches the block through a plain register port. A write happens in any cycle where `wr_en` is high. Reads are combinational from `rd_addr`. There is no streaming data path and no back-pressure: every control and status pin is a plain level. Reload and compare values take effect as soon as they are written, with no shadow copy. A one-pulse option stops the counter by itself at the first update event, which gives a single period and then idle.

Top module: `pwm_compare_channel`

## Requirements
- R1: While the enable bit (register 0, bit 0) is 1, each cycle with `tick` high moves the count up by one. In a tick where the count equals the reload value (register 1), the count goes to 0 instead. Without `tick`, or with the enable bit 0, the count holds. The count reads back at register 5.
- R2: A tick where the count equals the reload value while enabled is an update event. When the one-pulse bit (register 0, bit 1) is 1, the update event clears the enable bit, so the count stays at 0. A software write to register 0 in the same cycle takes priority over this clear.
- R3: The mode field is register 3, bits 2:0. In mode 001 the reference goes active at a tick where count equals the compare value (register 2). Mode 010 makes it inactive at such a tick, and mode 011 inverts it. Mode 000 holds the reference unchanged.
- R4: In mode 110 the reference is active while count < compare, and inactive otherwise. Mode 111 is the inverse. With compare above reload, mode 110 stays active for the whole period. With compare 0, mode 110 never goes active.
- R5: Mode 100 makes the reference inactive, and mode 101 makes it active, from the cycle after the mode write, independent of count. The level they force is kept when the mode is later changed to 000.
- R6: When the output-enable bit (register 3, bit 4) is 1, `pin_valid` is 1 and `pin` equals the reference XOR the polarity bit (register 3, bit 3; 0 means active high). When the output-enable bit is 0, `pin` and `pin_valid` are both 0.
- R7: Register 4 holds two flags. Bit 0 is set by each update event. Bit 1 is set by each tick where count equals compare while enabled. Writing 0 to a bit clears it. Writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: After reset, every register reads 0, and `pin` and `pin_valid` are 0.
- R9: A new reload or compare value governs the very next tick after the write. Registers 0 to 3 read back the values written, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle counter step strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pin | output | 1 | Channel output level |
| pin_valid | output | 1 | High when the channel drives `pin` |

## Verification
The assertions check every cycle that:
- the count wraps to zero and holds outside enabled ticks;
- one-pulse mode drops the enable after the update event;
- the update flag is raised after each update event;
- the pin follows the PWM comparisons and the force modes through the polarity stage;
- an undriven pin is always low.

Only the bench scenarios can show the sequence-dependent behaviour:
- the reference history carried by the set, clear and toggle modes across many periods;
- the always-active and never-active duty corners;
- write-0-to-clear and its race with a hardware set;
- immediate reload changes that land below the running count.

The bench checks these against a cycle model written from the requirements, driven by random register traffic.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    CM_HOLD     = 3'd0,
    CM_SET      = 3'd1,
    CM_CLEAR    = 3'd2,
    CM_TOGGLE   = 3'd3,
    CM_FORCE_LO = 3'd4,
    CM_FORCE_HI = 3'd5,
    CM_PWM_LEAD = 3'd6,
    CM_PWM_LAG  = 3'd7
  } cmp_mode_e;

  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_RELOAD = 3'd1;
  localparam logic [REG_AW-1:0] RA_CMP    = 3'd2;
  localparam logic [REG_AW-1:0] RA_CHAN   = 3'd3;
  localparam logic [REG_AW-1:0] RA_FLAGS  = 3'd4;
  localparam logic [REG_AW-1:0] RA_COUNT  = 3'd5;
endpackage

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          wrap
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step  = tick & run;
  assign wrap  = step & (cnt_q == reload);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= wrap ? '0 : cnt_q + ONE;
  end

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
endmodule

// File: rtl/pcc_compare.sv
module pcc_compare
  import pcc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_val,
  input  cmp_mode_e     mode,
  output logic          match,
  output logic          ref_lvl
);
  logic ref_q;
  logic below;

  assign match = tick & run & (count == cmp_val);
  assign below = count < cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else begin
      unique case (mode)
        CM_SET:      if (match) ref_q <= 1'b1;
        CM_CLEAR:    if (match) ref_q <= 1'b0;
        CM_TOGGLE:   if (match) ref_q <= ~ref_q;
        CM_FORCE_LO: ref_q <= 1'b0;
        CM_FORCE_HI: ref_q <= 1'b1;
        default:     ref_q <= ref_q;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      CM_PWM_LEAD: ref_lvl = below;
      CM_PWM_LAG:  ref_lvl = ~below;
      CM_FORCE_LO: ref_lvl = 1'b0;
      CM_FORCE_HI: ref_lvl = 1'b1;
      default:     ref_lvl = ref_q;
    endcase
  end

  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_SET && match) |=> (ref_q || mode == CM_FORCE_LO || mode == CM_CLEAR));
  a_r3_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD) |=> $stable(ref_q));
endmodule

// File: rtl/pcc_outstage.sv
module pcc_outstage (
  input  logic ref_lvl,
  input  logic active_low,
  input  logic drive_en,
  output logic pin,
  output logic pin_valid
);
  assign pin       = drive_en & (ref_lvl ^ active_low);
  assign pin_valid = drive_en;
endmodule

// File: rtl/pwm_compare_channel.sv
module pwm_compare_channel
  import pcc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic              pin,
  output logic              pin_valid
);
  localparam int unsigned PAD2 = CW - 2;
  localparam int unsigned PAD5 = CW - 5;

  logic          run_q, one_shot_q, pol_q, oe_q, upd_flag_q, cmp_flag_q;
  logic [CW-1:0] reload_q, cmp_q, count;
  cmp_mode_e     mode_q;
  logic          wrap, match, ref_lvl;
  logic          wr_ctrl, wr_rel, wr_cmp, wr_chan, wr_flags;

  assign wr_ctrl  = wr_en & (wr_addr == RA_CTRL);
  assign wr_rel   = wr_en & (wr_addr == RA_RELOAD);
  assign wr_cmp   = wr_en & (wr_addr == RA_CMP);
  assign wr_chan  = wr_en & (wr_addr == RA_CHAN);
  assign wr_flags = wr_en & (wr_addr == RA_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      one_shot_q <= 1'b0;
      reload_q   <= '0;
      cmp_q      <= '0;
      mode_q     <= CM_HOLD;
      pol_q      <= 1'b0;
      oe_q       <= 1'b0;
      upd_flag_q <= 1'b0;
      cmp_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= wr_data[0];
        one_shot_q <= wr_data[1];
      end else if (one_shot_q && wrap) begin
        run_q <= 1'b0;
      end
      if (wr_rel) reload_q <= wr_data;
      if (wr_cmp) cmp_q    <= wr_data;
      if (wr_chan) begin
        mode_q <= cmp_mode_e'(wr_data[2:0]);
        pol_q  <= wr_data[3];
        oe_q   <= wr_data[4];
      end
      upd_flag_q <= wrap  | (upd_flag_q & ~(wr_flags & ~wr_data[0]));
      cmp_flag_q <= match | (cmp_flag_q & ~(wr_flags & ~wr_data[1]));
    end
  end

  always_comb begin
    unique case (rd_addr)
      RA_CTRL:   rd_data = {{PAD2{1'b0}}, one_shot_q, run_q};
      RA_RELOAD: rd_data = reload_q;
      RA_CMP:    rd_data = cmp_q;
      RA_CHAN:   rd_data = {{PAD5{1'b0}}, oe_q, pol_q, mode_q};
      RA_FLAGS:  rd_data = {{PAD2{1'b0}}, cmp_flag_q, upd_flag_q};
      RA_COUNT:  rd_data = count;
      default:   rd_data = '0;
    endcase
  end

  pcc_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q),
    .reload(reload_q), .count(count), .wrap(wrap)
  );

  pcc_compare #(.CW(CW)) u_compare (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q), .count(count),
    .cmp_val(cmp_q), .mode(mode_q), .match(match), .ref_lvl(ref_lvl)
  );

  pcc_outstage u_out (
    .ref_lvl(ref_lvl), .active_low(pol_q), .drive_en(oe_q),
    .pin(pin), .pin_valid(pin_valid)
  );

  a_r2_one_pulse_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (one_shot_q && wrap && !wr_ctrl) |=> !run_q);
  a_r7_update_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> upd_flag_q);
  a_r4_pwm_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_PWM_LEAD && oe_q && !pol_q && count >= cmp_q) |-> !pin);
  a_r4_pwm_lag_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_PWM_LAG && oe_q && !pol_q && count >= cmp_q) |-> pin);
  a_r5_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_FORCE_HI && oe_q) |-> (pin == !pol_q));
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_valid |-> !pin);
endmodule

// File: tb/test_pwm_compare_channel.sv
`timescale 1ns/1ps
module test_pwm_compare_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pin, pin_valid;

  int n_run = 0;
  int n_fail = 0;

  // model state
  logic [15:0] m_cnt, m_arr, m_ccr;
  logic        m_run, m_os, m_pol, m_oe, m_ref, m_uf, m_cf;
  logic [2:0]  m_mode;

  always #2 clk = ~clk;

  pwm_compare_channel i_pwm_compare_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin(pin), .pin_valid(pin_valid)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_ref();
    case (m_mode)
      3'd6: return m_cnt < m_ccr;
      3'd7: return !(m_cnt < m_ccr);
      3'd4: return 1'b0;
      3'd5: return 1'b1;
      default: return m_ref;
    endcase
  endfunction

  function automatic string pin_tag();
    case (m_mode)
      3'd6, 3'd7: return "R4 pin";
      3'd4, 3'd5: return "R5 pin";
      default:    return "R3 pin";
    endcase
  endfunction

  task automatic check_all();
    chk(pin_tag(), pin, m_oe ? int'(exp_ref() ^ m_pol) : 0);
    chk("R6 pin_valid", pin_valid, m_oe);
    rd_addr = 3'd5; #0.2;
    chk("R1 count", rd_data, m_cnt);
    rd_addr = 3'd4; #0.2;
    chk("R7 flags", rd_data, {m_cf, m_uf});
    rd_addr = 3'd0; #0.2;
    chk("R2 ctrl", rd_data, {m_os, m_run});
  endtask

  task automatic step(bit tk, bit we, logic [2:0] a, logic [15:0] d);
    logic upd, mt, n_ref;
    tick = tk; wr_en = we; wr_addr = a; wr_data = d;
    upd = tk && m_run && (m_cnt == m_arr);
    mt  = tk && m_run && (m_cnt == m_ccr);
    n_ref = m_ref;
    case (m_mode)
      3'd1: if (mt) n_ref = 1'b1;
      3'd2: if (mt) n_ref = 1'b0;
      3'd3: if (mt) n_ref = ~m_ref;
      3'd4: n_ref = 1'b0;
      3'd5: n_ref = 1'b1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    if (tk && m_run) m_cnt = upd ? 16'd0 : m_cnt + 16'd1;
    m_ref = n_ref;
    m_uf = upd | (m_uf & ~(we && a == 3'd4 && !d[0]));
    m_cf = mt  | (m_cf & ~(we && a == 3'd4 && !d[1]));
    if (we && a == 3'd0) begin m_run = d[0]; m_os = d[1]; end
    else if (m_os && upd) m_run = 1'b0;
    if (we && a == 3'd1) m_arr = d;
    if (we && a == 3'd2) m_ccr = d;
    if (we && a == 3'd3) begin m_mode = d[2:0]; m_pol = d[3]; m_oe = d[4]; end
    tick = 1'b0; wr_en = 1'b0;
    check_all();
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 16'd0);
  endtask

  initial begin
    #300000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_arr = 0; m_ccr = 0; m_run = 0; m_os = 0; m_pol = 0;
    m_oe = 0; m_ref = 0; m_uf = 0; m_cf = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    chk("R8 pin after reset", pin, 0);
    chk("R8 pin_valid after reset", pin_valid, 0);
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a); #0.2;
      chk("R8 register after reset", rd_data, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 readback
    wr(3'd1, 16'd4); wr(3'd2, 16'd2); wr(3'd3, 16'h0016);
    rd_addr = 3'd3; #0.2; chk("R9 chan readback", rd_data, 16'h0016);
    rd_addr = 3'd1; #0.2; chk("R9 reload readback", rd_data, 4);
    // R4 PWM lead, then lag with active-low
    wr(3'd0, 16'd1);
    run_ticks(12);
    wr(3'd3, 16'h001F);
    run_ticks(12);
    // R4 corners: compare above reload, compare zero
    wr(3'd3, 16'h0016); wr(3'd2, 16'd9); run_ticks(10);
    wr(3'd2, 16'd0); run_ticks(10);
    // R3 toggle/set/clear and frozen
    wr(3'd2, 16'd3); wr(3'd3, 16'h0013); run_ticks(15);
    wr(3'd3, 16'h0010); run_ticks(8);
    wr(3'd3, 16'h0011); run_ticks(6);
    wr(3'd3, 16'h0012); run_ticks(6);
    // R5 force, and hold after force
    wr(3'd3, 16'h0015); run_ticks(3);
    wr(3'd3, 16'h0010); run_ticks(3);
    wr(3'd3, 16'h0014); run_ticks(3);
    // R6 output disabled
    wr(3'd3, 16'h0005); run_ticks(3);
    // R7 clears: write 1s, then clear update flag only
    wr(3'd4, 16'h0003); wr(3'd4, 16'h0002); wr(3'd4, 16'h0000);
    // R9 reload below running count then R2 one-pulse
    wr(3'd1, 16'd6); run_ticks(4); wr(3'd1, 16'd2); run_ticks(20);
    wr(3'd0, 16'd3); run_ticks(10);
    wr(3'd4, 16'h0000);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      bit tk = ($urandom % 4) != 0;
      if (($urandom % 6) == 0) begin
        logic [2:0] a = 3'($urandom % 5);
        logic [15:0] d;
        case (a)
          3'd0: d = 16'($urandom % 4) | 16'd1;
          3'd1, 3'd2: d = 16'($urandom % 9);
          3'd4: d = 16'($urandom % 4);
          default: d = 16'($urandom % 32);
        endcase
        if (a == 3'd0 && ($urandom % 5) == 0) d = 16'($urandom % 4);
        step(tk, 1'b1, a, d);
      end else begin
        step(tk, 1'b0, 3'd0, 16'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule